// File: doc/BRIEF.md
# Automatic Reseed Scheduler

This block decides when a random generator has to refresh its seed without being told to by the host. It watches two things: how many host generate requests have completed, and how many time ticks have gone by. Each has its own countdown. When either countdown runs out, the block sends a single-cycle reseed request to the command sequencer.

Each countdown restarts from its own reload value. Software writes the reload values through a small register write port: 0x60 holds the request-count limit and 0x64 holds the age limit, both 16 bits wide. A reload value of zero turns that policy off. Whenever a reseed completes, whoever started it, both countdowns restart. If triggers arrive while an automatic reseed is still running, they collapse into one pending request. That request is released when the running reseed completes.

Top module: `reseed_scheduler`

## Requirements
- R1: After reset, `reseed_req` is low and both reload values are zero, so neither policy is active.
- R2: A write to address 0x60 sets the request-count reload value and a write to 0x64 sets the age reload value. A write to any other address changes neither policy.
- R3: A policy whose reload value is zero never produces a request, whatever `gen_done` or `tick` do.
- R4: With a request-count reload value N > 0, the Nth `gen_done` pulse after the counter was last loaded raises a request.
- R5: With an age reload value N > 0, the age countdown moves only on cycles with `tick` high, and the Nth tick after it was loaded raises a request. Clock cycles without a tick, and `gen_done` pulses, leave it unchanged.
- R6: `reseed_req` is a registered pulse. It is high for exactly the one cycle after the triggering event, unless a new release falls on the next cycle.
- R7: Any trigger, from either policy, reloads both countdowns from their reload values.
- R8: A `reseed_done` pulse reloads both countdowns, including for a reseed the host started.
- R9: If both countdowns run out on the same cycle, only one request pulse is issued.
- R10: From a request until the next `reseed_done`, further triggers set one pending flag. At that `reseed_done`, exactly one request is issued, however many triggers were held.
- R11: Writing a reload value restarts the matching countdown from the new value at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 16 | Register write data |
| gen_done | input | 1 | One-cycle pulse: a host generate request completed |
| reseed_done | input | 1 | One-cycle pulse: a reseed completed |
| tick | input | 1 | Prescaled time-tick enable |
| reseed_req | output | 1 | One-cycle automatic reseed request |

## Verification
The assertions take `gen_done`, `tick` and `reseed_done` to be single-cycle event pulses. They also take `reseed_done` to be the sequencer's response to a request or to a host reseed, never a free-running signal. The stimulus drives each event for exactly one cycle, on the falling edge. It never puts a register write on the same cycle as a counting event. Every scenario starts by clearing both reload values and issuing one completion, so no pending state carries over from the previous scenario.

// File: rtl/reseed_scheduler.sv
module reseed_scheduler #(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REQ_ADDR = 'h60,
  parameter logic [ADDR_W-1:0] AGE_ADDR = 'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic              gen_done,
  input  logic              reseed_done,
  input  logic              tick,
  output logic              reseed_req
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] req_reload, age_reload, req_cnt, age_cnt;
  logic busy, pending;

  wire req_en  = |req_reload;
  wire age_en  = |age_reload;
  wire req_hit = req_en & gen_done & (req_cnt == ONE);
  wire age_hit = age_en & tick & (age_cnt == ONE);
  wire trig    = req_hit | age_hit;
  wire restart = trig | reseed_done;
  wire busy_n  = busy & ~reseed_done;
  wire want    = trig | pending;
  wire fire    = want & ~busy_n;
  wire wr_req  = cfg_we & (cfg_addr == REQ_ADDR);
  wire wr_age  = cfg_we & (cfg_addr == AGE_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_reload <= '0;
      req_cnt    <= '0;
    end else if (wr_req) begin
      req_reload <= cfg_wdata;
      req_cnt    <= cfg_wdata;
    end else if (restart) begin
      req_cnt    <= req_reload;
    end else if (req_en & gen_done) begin
      req_cnt    <= req_cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_reload <= '0;
      age_cnt    <= '0;
    end else if (wr_age) begin
      age_reload <= cfg_wdata;
      age_cnt    <= cfg_wdata;
    end else if (restart) begin
      age_cnt    <= age_reload;
    end else if (age_en & tick) begin
      age_cnt    <= age_cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reseed_req <= 1'b0;
      busy       <= 1'b0;
      pending    <= 1'b0;
    end else begin
      reseed_req <= fire;
      busy       <= fire | busy_n;
      pending    <= want & ~fire;
    end
  end
endmodule

module reseed_scheduler_chk #(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REQ_ADDR = 'h60,
  parameter logic [ADDR_W-1:0] AGE_ADDR = 'h64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [CNT_W-1:0]  cfg_wdata,
  input logic              gen_done,
  input logic              reseed_done,
  input logic              tick,
  input logic              reseed_req,
  input logic [CNT_W-1:0]  req_reload,
  input logic [CNT_W-1:0]  age_reload,
  input logic [CNT_W-1:0]  req_cnt,
  input logic [CNT_W-1:0]  age_cnt,
  input logic              busy,
  input logic              pending
);
  assert_write_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == REQ_ADDR) |=> (req_cnt == $past(cfg_wdata)));

  assert_age_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_we && !reseed_done && !gen_done) |=> $stable(age_cnt));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_reload == '0 && age_reload == '0 && !pending && !busy) |=> !reseed_req);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reseed_req && !reseed_done) |=> !reseed_req);

  assert_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reseed_req) |-> $past(gen_done || tick || reseed_done));

  assert_pending_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> busy);

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reseed_done && pending) |=> reseed_req);
endmodule

bind reseed_scheduler reseed_scheduler_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .REQ_ADDR(REQ_ADDR), .AGE_ADDR(AGE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .gen_done(gen_done), .reseed_done(reseed_done),
  .tick(tick), .reseed_req(reseed_req), .req_reload(req_reload),
  .age_reload(age_reload), .req_cnt(req_cnt), .age_cnt(age_cnt),
  .busy(busy), .pending(pending)
);

// File: tb/tb_reseed_scheduler.sv
module tb_reseed_scheduler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic gen_done = 1'b0, reseed_done = 1'b0, tick = 1'b0;
  logic reseed_req;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  reseed_scheduler dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .gen_done(gen_done), .reseed_done(reseed_done),
    .tick(tick), .reseed_req(reseed_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: reseed_req=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic g, input logic t, input logic d, input string req, input logic exp);
    @(negedge clk);
    gen_done = g; tick = t; reseed_done = d;
    @(negedge clk);
    gen_done = 0; tick = 0; reseed_done = 0;
    chk(req, reseed_req, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic clean();
    wr(8'h60, 0); wr(8'h64, 0);
    step(0, 0, 1, "clean", 0);
  endtask

  task automatic t_reset();
    chk("R1", reseed_req, 0);
    for (int i = 0; i < 3; i++) step(1, 1, 0, "R1", 0);
  endtask

  task automatic t_disabled();
    clean();
    for (int i = 0; i < 6; i++) step(1, 0, 0, "R3", 0);
    for (int i = 0; i < 6; i++) step(0, 1, 0, "R3", 0);
  endtask

  task automatic t_count();
    clean();
    wr(8'h60, 3);
    step(1, 0, 0, "R4", 0); step(1, 0, 0, "R4", 0); step(1, 0, 0, "R4", 1);
    step(0, 0, 0, "R6", 0);
    step(0, 0, 1, "R6", 0);
    step(1, 0, 0, "R7", 0); step(1, 0, 0, "R7", 0); step(1, 0, 0, "R7", 1);
  endtask

  task automatic t_age();
    clean();
    wr(8'h64, 4);
    for (int i = 0; i < 10; i++) step(0, 0, 0, "R5", 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R5", 0);
    step(0, 1, 0, "R5", 0); step(0, 1, 0, "R5", 0); step(0, 1, 0, "R5", 0);
    step(0, 1, 0, "R5", 1);
  endtask

  task automatic t_cross_reload();
    clean();
    wr(8'h60, 3); wr(8'h64, 5);
    step(0, 1, 0, "R7", 0); step(0, 1, 0, "R7", 0);
    step(1, 0, 0, "R7", 0); step(1, 0, 0, "R7", 0); step(1, 0, 0, "R7", 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, "R7", 0);
    step(0, 0, 1, "R7", 0);
    for (int i = 0; i < 4; i++) step(0, 1, 0, "R8", 0);
    step(0, 1, 0, "R8", 1);
  endtask

  task automatic t_done_reload();
    clean();
    wr(8'h60, 3);
    step(1, 0, 0, "R8", 0); step(1, 0, 0, "R8", 0);
    step(0, 0, 1, "R8", 0);
    step(1, 0, 0, "R8", 0); step(1, 0, 0, "R8", 0); step(1, 0, 0, "R8", 1);
  endtask

  task automatic t_both();
    clean();
    wr(8'h60, 2); wr(8'h64, 2);
    step(1, 1, 0, "R9", 0);
    step(1, 1, 0, "R9", 1);
    step(0, 0, 0, "R9", 0);
    step(0, 0, 1, "R9", 0);
  endtask

  task automatic t_pending();
    clean();
    wr(8'h60, 1); wr(8'h64, 1);
    step(1, 0, 0, "R10", 1);
    step(1, 0, 0, "R10", 0);
    step(0, 1, 0, "R10", 0);
    step(1, 1, 0, "R10", 0);
    step(0, 0, 1, "R10", 1);
    step(0, 0, 0, "R10", 0);
    step(0, 0, 1, "R10", 0);
    step(0, 0, 0, "R10", 0);
  endtask

  task automatic t_rewrite();
    clean();
    wr(8'h60, 5);
    step(1, 0, 0, "R11", 0); step(1, 0, 0, "R11", 0);
    wr(8'h60, 2);
    step(1, 0, 0, "R11", 0); step(1, 0, 0, "R11", 1);
    step(0, 0, 1, "R11", 0);
    wr(8'h68, 1);
    step(1, 0, 0, "R2", 0); step(1, 0, 0, "R2", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_count();
    t_age();
    t_cross_reload();
    t_done_reload();
    t_both();
    t_pending();
    t_rewrite();
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule